// File: doc/BRIEF.md
# Indexed audio codec register interface

This block is the host-facing control front of an audio codec. A host reaches it through four byte-wide ports picked by the two low address bits. The index port selects one of up to 32 indirect byte registers, and the data port reads or writes that register. The status port reports and clears the pending interrupt. The programmed-I/O data port is inert. Accesses are one-cycle read or write strobes on an 8-bit bus. A read returns its value combinationally in the same cycle, and any side effect of the read takes place on that strobe's clock edge.

Several registers follow special rules. The rate/format byte is writable in full only while the mode-change-enable bit of the index port is set. A separate playback mode-change bit allows only its upper nibble to be written. A mode bit widens the index from four to five bits. Reads of the error/init register report an auto-calibration busy flag for a programmed number of reads after mode-change-enable rises. The block passes playback enable, interrupt enable, the format byte and the mode bit on to the playback engine. It raises its interrupt when that engine signals the end of a period.

Top module: `codec_regif`

## Requirements
- R1: Port offset 0 is the index port, 1 the indexed data port, 2 the status port and 3 the PIO data port. Index port reads return bit 7 as 0, and bit 7 is never stored. The PIO port reads 0x00, and writes to it have no effect.
- R2: When bit 6 of indirect register 12 is clear, index bits 3:0 select the register and index bit 4 is ignored. When that bit is set, index bits 4:0 select it.
- R3: A write to register 8 stores the full byte when index bit 6 (mode-change enable) is set. With that bit clear and bit 4 of register 24 set, only bits 7:4 are stored and bits 3:0 keep their value. Otherwise the write is ignored. Output `fmt_byte` equals register 8.
- R4: Writes to register 9 store the byte with bit 5 forced to 0. When the written bit 6 is 0, `play_en` takes written bit 0. When the written bit 6 is 1, `play_en` keeps its value.
- R5: Only bit 6 of register 12 is writable, and the other bits keep their value. Output `mode2` equals register 12 bit 6.
- R6: Writes to register 11 and to reserved registers 22, 27 and 29 are ignored, and those registers read 0x00 after reset.
- R7: Index bit 6 may rise from 0 to 1 through an index-port write while bit 3 or bit 4 of register 9 is set. When it does, a calibration counter loads CAL_COUNT. Each data-port read of register 11 while the counter is nonzero returns bit 5 set and decrements the counter.
- R8: Any write to the status port clears the interrupt flag (status bit 0) and bits 6:4 of register 24, and drops `irq`.
- R9: A data write to register 24 that turns bit 4 from 1 to 0 clears the interrupt flag and drops `irq`. A write that keeps bit 4 set leaves it raised.
- R10: Reset values are: index port 0x40, register 9 0x08, register 12 0x8A, registers 25 and 26 0xA0, registers 2–5 and 18–19 0x88, registers 6–7 0x80, and every other register 0x00.
- R11: A `play_done` pulse sets the interrupt flag and bit 4 of register 24. `irq` equals the flag, and a status-port read returns the flag in bit 0 with the other bits 0.
- R12: Output `irq_en` equals bit 1 of register 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Port select |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| play_done | input | 1 | End-of-period pulse from the playback engine |
| play_en | output | 1 | Playback enable |
| irq_en | output | 1 | Interrupt enable |
| fmt_byte | output | 8 | Rate and format byte |
| mode2 | output | 1 | Extended index mode |
| irq | output | 1 | Interrupt level |

## Verification
Register 8 is written with the same data in three gating states: mode-change enable set, only the playback mode-change bit set, and neither set. The full, nibble-merged and unchanged readbacks separate these states. Index 0x18 is read with the mode bit clear and again with it set, which shows whether index bit 4 is dropped. The calibration flag is read twice after a mode-change-enable rise, and again after a rise with register 9 bits 3 and 4 cleared, to check both the count and the load condition. The interrupt is raised by `play_done` and then cleared through the status port, through a falling bit 4 of register 24, and not cleared by a write that keeps bit 4 set.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;

    typedef enum logic [1:0] {
        PORT_INDEX  = 2'd0,
        PORT_DATA   = 2'd1,
        PORT_STATUS = 2'd2,
        PORT_PIO    = 2'd3
    } port_e;

    localparam int REG_FMT     = 8;
    localparam int REG_IFCFG   = 9;
    localparam int REG_PINCTL  = 10;
    localparam int REG_ERRINIT = 11;
    localparam int REG_MODE    = 12;
    localparam int REG_RSV_A   = 22;
    localparam int REG_ALTSTAT = 24;
    localparam int REG_RSV_B   = 27;
    localparam int REG_RSV_C   = 29;

    localparam logic [6:0] INDEX_RESET = 7'h40;
    localparam int         MCE_BIT     = 6;
    localparam int         PMCE_BIT    = 4;
    localparam int         MODE2_BIT   = 6;
    localparam logic [7:0] CAL_FLAG    = 8'h20;

    function automatic logic [7:0] reg_reset_value(input int idx);
        case (idx)
            2, 3, 4, 5, 18, 19: return 8'h88;
            6, 7:               return 8'h80;
            REG_IFCFG:          return 8'h08;
            REG_MODE:           return 8'h8A;
            25, 26:             return 8'hA0;
            default:            return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/codec_regif_cal.sv
module codec_regif_cal #(
    parameter int CAL_COUNT = 1,
    parameter int CAL_W     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic rd_hit,
    output logic busy
);
    typedef struct packed {
        logic [CAL_W-1:0] cnt;
    } cal_st_t;

    cal_st_t cal_d, cal_q;

    always_comb begin
        cal_d = cal_q;
        if (rd_hit && cal_q.cnt != '0)
            cal_d.cnt = cal_q.cnt - 1'b1;
        if (load)
            cal_d.cnt = CAL_W'(CAL_COUNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= '0;
        else        cal_q <= cal_d;
    end

    assign busy = (cal_q.cnt != '0);

    // R7: each flagged read consumes exactly one count
    p_cal_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && busy && !load) |=> (cal_q.cnt == $past(cal_q.cnt) - 1'b1));

    // R7: counter only moves when a read or a load happens
    p_cal_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_hit && !load) |=> $stable(cal_q.cnt));

endmodule

// File: rtl/codec_regif_bank.sv
module codec_regif_bank
    import codec_regif_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_strobe,
    input  logic [IDX_W-1:0] wr_sel,
    input  logic [7:0]       wdata,
    input  logic             mce,
    input  logic             stat_clr,
    input  logic             play_done,
    output logic [7:0]       regs_o [NREG],
    output logic             intr_o,
    output logic             play_en_o
);
    typedef struct packed {
        logic [NREG-1:0][7:0] regs;
        logic                 intr;
        logic                 play_en;
    } bank_st_t;

    bank_st_t bank_d, bank_q;

    function automatic bank_st_t bank_reset();
        bank_st_t r;
        r = '0;
        for (int i = 0; i < NREG; i++)
            r.regs[i] = reg_reset_value(i);
        return r;
    endfunction

    always_comb begin
        bank_d = bank_q;
        if (wr_strobe) begin
            case (int'(wr_sel))
                REG_FMT: begin
                    if (mce)
                        bank_d.regs[REG_FMT] = wdata;
                    else if (bank_q.regs[REG_ALTSTAT][PMCE_BIT])
                        bank_d.regs[REG_FMT] = {wdata[7:4], bank_q.regs[REG_FMT][3:0]};
                end
                REG_IFCFG: begin
                    bank_d.regs[REG_IFCFG] = wdata & 8'hDF;
                    if (!wdata[6])
                        bank_d.play_en = wdata[0];
                end
                REG_ERRINIT, REG_RSV_A, REG_RSV_B, REG_RSV_C: ;
                REG_MODE:
                    bank_d.regs[REG_MODE][MODE2_BIT] = wdata[MODE2_BIT];
                REG_ALTSTAT: begin
                    bank_d.regs[REG_ALTSTAT] = wdata;
                    if (bank_q.regs[REG_ALTSTAT][PMCE_BIT] && !wdata[PMCE_BIT])
                        bank_d.intr = 1'b0;
                end
                default:
                    bank_d.regs[wr_sel] = wdata;
            endcase
        end
        if (stat_clr) begin
            bank_d.intr                   = 1'b0;
            bank_d.regs[REG_ALTSTAT][6:4] = 3'b000;
        end
        if (play_done) begin
            bank_d.intr                        = 1'b1;
            bank_d.regs[REG_ALTSTAT][PMCE_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= bank_reset();
        else        bank_q <= bank_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign regs_o[g] = bank_q.regs[g];
    end
    assign intr_o    = bank_q.intr;
    assign play_en_o = bank_q.play_en;

    // R6: the error/init register cannot be written
    p_errinit_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && int'(wr_sel) == REG_ERRINIT) |=> $stable(bank_q.regs[REG_ERRINIT]));

    // R3: format byte is frozen when neither enable bit is set
    p_fmt_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && int'(wr_sel) == REG_FMT && !mce && !bank_q.regs[REG_ALTSTAT][PMCE_BIT])
        |=> $stable(bank_q.regs[REG_FMT]));

    // R5: mode register keeps all bits other than bit 6
    p_mode_ro_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && int'(wr_sel) == REG_MODE)
        |=> ($stable(bank_q.regs[REG_MODE][5:0]) && $stable(bank_q.regs[REG_MODE][7])));

    // R8: a status write with no new event leaves nothing pending
    p_stat_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !play_done) |=> (!bank_q.intr && bank_q.regs[REG_ALTSTAT][6:4] == 3'b000));

    // R11: end-of-period always raises the flag
    p_done_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        play_done |=> (bank_q.intr && bank_q.regs[REG_ALTSTAT][PMCE_BIT]));

endmodule

// File: rtl/codec_regif.sv
module codec_regif
    import codec_regif_pkg::*;
#(
    parameter int NREG      = 32,
    parameter int CAL_COUNT = 1,
    parameter int CAL_W     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       play_done,
    output logic       play_en,
    output logic       irq_en,
    output logic [7:0] fmt_byte,
    output logic       mode2,
    output logic       irq
);
    localparam int IDX_W = $clog2(NREG);

    typedef struct packed {
        logic [6:0] idx;
    } top_st_t;

    top_st_t    top_d, top_q;
    logic [7:0] regs [NREG];
    logic       intr;
    logic       cal_busy;
    logic [IDX_W-1:0] sel;
    logic       wr_index, wr_data, wr_status, rd_data, cal_load, cal_rd;

    assign wr_index  = wr_en && addr == PORT_INDEX;
    assign wr_data   = wr_en && addr == PORT_DATA;
    assign wr_status = wr_en && addr == PORT_STATUS;
    assign rd_data   = rd_en && addr == PORT_DATA;

    assign mode2 = regs[REG_MODE][MODE2_BIT];
    assign sel   = mode2 ? top_q.idx[IDX_W-1:0] : IDX_W'(top_q.idx[3:0]);

    assign cal_load = wr_index && !top_q.idx[MCE_BIT] && wdata[MCE_BIT]
                      && (regs[REG_IFCFG][4] || regs[REG_IFCFG][3]);
    assign cal_rd   = rd_data && int'(sel) == REG_ERRINIT;

    always_comb begin
        top_d = top_q;
        if (wr_index)
            top_d.idx = wdata[6:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '{idx: INDEX_RESET};
        else        top_q <= top_d;
    end

    codec_regif_bank #(.NREG(NREG)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_data),
        .wr_sel    (sel),
        .wdata     (wdata),
        .mce       (top_q.idx[MCE_BIT]),
        .stat_clr  (wr_status),
        .play_done (play_done),
        .regs_o    (regs),
        .intr_o    (intr),
        .play_en_o (play_en)
    );

    codec_regif_cal #(.CAL_COUNT(CAL_COUNT), .CAL_W(CAL_W)) cal_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cal_load),
        .rd_hit (cal_rd),
        .busy   (cal_busy)
    );

    always_comb begin
        case (addr)
            PORT_INDEX:  rdata = {1'b0, top_q.idx};
            PORT_DATA:   rdata = regs[sel] | ((cal_busy && int'(sel) == REG_ERRINIT) ? CAL_FLAG : 8'h00);
            PORT_STATUS: rdata = {7'b0, intr};
            default:     rdata = 8'h00;
        endcase
    end

    assign irq      = intr;
    assign irq_en   = regs[REG_PINCTL][1];
    assign fmt_byte = regs[REG_FMT];

    // R1: index port never reports bit 7
    p_idx_bit7_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == PORT_INDEX) |-> (rdata[7] == 1'b0));

    // R8: status write drops the interrupt line on the next cycle
    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !play_done) |=> !irq);

    // R1: PIO port reads as zero
    p_pio_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == PORT_PIO) |-> (rdata == 8'h00));

endmodule

// File: tb/codec_regif_tb_top.sv
module codec_regif_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       play_done = 1'b0;
    logic       play_en, irq_en, mode2, irq;
    logic [7:0] fmt_byte;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    codec_regif dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wdata     (wdata),
        .rdata     (rdata),
        .play_done (play_done),
        .play_en   (play_en),
        .irq_en    (irq_en),
        .fmt_byte  (fmt_byte),
        .mode2     (mode2),
        .irq       (irq)
    );

    // {is_read, port, data, expected, requirement number}
    localparam int NVEC = 22;
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 8'h00, 8'h40, 4'd10}, // R10 index reset
        {1'b0, 2'd0, 8'h4C, 8'h00, 4'd0},
        {1'b1, 2'd1, 8'h00, 8'h8A, 4'd10}, // R10 reg12
        {1'b0, 2'd0, 8'h49, 8'h00, 4'd0},
        {1'b1, 2'd1, 8'h00, 8'h08, 4'd10}, // R10 reg9
        {1'b0, 2'd0, 8'h42, 8'h00, 4'd0},
        {1'b1, 2'd1, 8'h00, 8'h88, 4'd10}, // R10 reg2
        {1'b0, 2'd0, 8'h47, 8'h00, 4'd0},
        {1'b1, 2'd1, 8'h00, 8'h80, 4'd10}, // R10 reg7
        {1'b0, 2'd0, 8'hC6, 8'h00, 4'd0},
        {1'b1, 2'd0, 8'h00, 8'h46, 4'd1},  // R1 bit 7 dropped
        {1'b1, 2'd1, 8'h00, 8'h80, 4'd10}, // R10 reg6
        {1'b0, 2'd0, 8'h48, 8'h00, 4'd0},
        {1'b0, 2'd1, 8'h5B, 8'h00, 4'd0},
        {1'b1, 2'd1, 8'h00, 8'h5B, 4'd3},  // R3 full write with MCE
        {1'b0, 2'd0, 8'h49, 8'h00, 4'd0},
        {1'b0, 2'd1, 8'hFF, 8'h00, 4'd0},
        {1'b1, 2'd1, 8'h00, 8'hDF, 4'd4},  // R4 bit 5 forced low
        {1'b1, 2'd2, 8'h00, 8'h00, 4'd11}, // R11 no interrupt
        {1'b1, 2'd3, 8'h00, 8'h00, 4'd1},  // R1 PIO reads zero
        {1'b0, 2'd3, 8'hFF, 8'h00, 4'd0},
        {1'b1, 2'd3, 8'h00, 8'h00, 4'd1}   // R1 PIO write ignored
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        play_done = 1'b1;
        @(negedge clk);
        play_done = 1'b0;
    endtask

    initial begin
        logic [7:0] v;
        do_reset();

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][22]) begin
                rd(VEC[i][21:20], v);
                total++;
                if (v !== VEC[i][11:4]) begin
                    bad++;
                    $display("FAIL R%0d: vector %0d got 0x%02h expected 0x%02h",
                             VEC[i][3:0], i, v, VEC[i][11:4]);
                end
            end else begin
                wr(VEC[i][21:20], VEC[i][19:12]);
            end
        end

        // R4 and R12: playback enable follows bit 0 unless PIO bit set
        do_reset();
        wr(0, 8'h49); wr(1, 8'h01);
        @(negedge clk); check("R4 enable on", {7'b0, play_en}, 8'h01);
        wr(1, 8'h40);
        @(negedge clk); check("R4 PIO keeps enable", {7'b0, play_en}, 8'h01);
        wr(1, 8'h00);
        @(negedge clk); check("R4 enable off", {7'b0, play_en}, 8'h00);
        wr(0, 8'h4A); wr(1, 8'h02);
        @(negedge clk); check("R12 irq_en", {7'b0, irq_en}, 8'h01);

        // R3 gating, R5 mode bit, R2 index width
        do_reset();
        wr(0, 8'h48); wr(1, 8'h5B);
        @(negedge clk); check("R3 fmt_byte", fmt_byte, 8'h5B);
        wr(0, 8'h08); wr(1, 8'hA3);
        rd(1, v); check("R3 ignored without enables", v, 8'h5B);
        wr(0, 8'h0C); wr(1, 8'hFF);
        rd(1, v); check("R5 only bit 6 written", v, 8'hCA);
        @(negedge clk); check("R5 mode2 out", {7'b0, mode2}, 8'h01);
        wr(0, 8'h18); wr(1, 8'h10);
        wr(0, 8'h08); wr(1, 8'hA3);
        rd(1, v); check("R3 upper nibble only", v, 8'hAB);
        wr(0, 8'h18);
        rd(1, v); check("R2 five-bit index", v, 8'h10);
        wr(0, 8'h0C); wr(1, 8'h00);
        wr(0, 8'h18);
        rd(1, v); check("R2 four-bit index aliases reg8", v, 8'hAB);

        // R6: read-only and reserved registers
        wr(0, 8'h0B); wr(1, 8'hFF);
        rd(1, v); check("R6 reg11 write ignored", v, 8'h00);
        wr(0, 8'h0C); wr(1, 8'h40);
        wr(0, 8'h16); wr(1, 8'h55);
        rd(1, v); check("R6 reg22 ignored", v, 8'h00);
        wr(0, 8'h1B); wr(1, 8'h55);
        rd(1, v); check("R6 reg27 ignored", v, 8'h00);
        wr(0, 8'h1D); wr(1, 8'h55);
        rd(1, v); check("R6 reg29 ignored", v, 8'h00);

        // R7: calibration busy flag
        do_reset();
        wr(0, 8'h0B); wr(0, 8'h4B);
        rd(1, v); check("R7 first read busy", v, 8'h20);
        rd(1, v); check("R7 count exhausted", v, 8'h00);
        wr(0, 8'h49); wr(1, 8'h00);
        wr(0, 8'h0B); wr(0, 8'h4B);
        rd(1, v); check("R7 no load when bits 3,4 clear", v, 8'h00);

        // R11 and R8: raise then clear through status port
        do_reset();
        wr(0, 8'h4C); wr(1, 8'h40);
        wr(0, 8'h58); wr(1, 8'h60);
        pulse_done();
        check("R11 irq raised", {7'b0, irq}, 8'h01);
        rd(2, v); check("R11 status bit 0", v, 8'h01);
        wr(0, 8'h58);
        rd(1, v); check("R11 reg24 bit 4 set", v, 8'h70);
        wr(2, 8'h00);
        @(negedge clk); check("R8 irq cleared", {7'b0, irq}, 8'h00);
        rd(1, v); check("R8 reg24 bits 6:4 cleared", v, 8'h00);

        // R9: clear through register 24 bit 4
        pulse_done();
        wr(1, 8'h30);
        @(negedge clk); check("R9 bit 4 kept keeps irq", {7'b0, irq}, 8'h01);
        wr(1, 8'h00);
        @(negedge clk); check("R9 bit 4 falling clears irq", {7'b0, irq}, 8'h00);
        rd(2, v); check("R9 status cleared", v, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: all requirements, got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule